// File: doc/BRIEF.md
# Sparse-Transition Automaton Walker

This block scans an 8-bit byte stream against a compressed deterministic automaton. The automaton is held in an on-block state table. Each state keeps a few labelled transitions, each a byte with its successor state, plus an optional fallback pointer and an accepting flag. For each byte, the walker compares the byte against every labelled transition of the current state at once. On a hit it consumes the byte and moves to the successor. On a miss it follows the fallback pointer to another state and retries the same byte there. It keeps the input stalled until some state along the fallback chain holds a labelled transition for the byte.

Fallback chains form trees, so a walk always ends at a root state. A root has no fallback pointer and carries its own labelled transitions. The number of fallback hops spent on one byte is capped by a parameter. A byte that exceeds the cap, or that misses at a state without a fallback pointer, sets a sticky error flag. That byte is dropped and the walk restarts from the configured start state. Rules are loaded through a table write port while no byte is pending. A start-of-packet pulse returns the walk to the start state.

Top module: `d2fa_engine`

## Requirements
- R1: After reset `state_o` equals `cfg_start`, and `match_o`, `step_o` and `err_o` are 0.
- R2: When a valid labelled entry of the current state carries `in_byte`, `in_ready` is high in that cycle, the byte is consumed, and `state_o` shows the entry's successor one cycle later.
- R3: When no entry of the current state matches and the state has a fallback pointer and hops remain, `in_ready` is low, the walker moves to the fallback state, and the same byte is retried in the next cycle. A byte needing N hops is consumed on the (N+1)-th cycle it is offered.
- R4: One cycle after a byte is consumed, `step_o` is 1 for one cycle. `match_o` is 1 in that cycle exactly when the new state's accepting flag is set.
- R5: After every consumed byte, `state_o` and `match_o` agree with the uncompressed automaton for the same input history.
- R6: Up to `MAX_HOPS` (default 4) fallback hops per byte are allowed. A byte needing more is dropped with `in_ready` high, `err_o` becomes 1 and stays 1 until reset, `state_o` returns to `cfg_start`, `match_o` is 0, and the next byte is processed normally.
- R7: A miss at a state without a fallback pointer is handled like R6: the byte is dropped, `err_o` is set and the walk returns to `cfg_start`.
- R8: A `sop` pulse sets `state_o` to `cfg_start` in the next cycle, holds `in_ready` low in its own cycle, and abandons any hops in progress.
- R9: A table write takes effect only while `in_valid` is low, no hops are pending and `sop` is low. A write issued while a byte is pending has no effect.
- R10: `tbl_kind`=0 writes the entry (`tbl_state`,`tbl_slot`) with label `tbl_byte`, successor `tbl_ptr` and valid bit `tbl_flag`. `tbl_kind`=1 writes the header of `tbl_state`: fallback `tbl_ptr`, fallback-present `tbl_aux` and accepting flag `tbl_flag`.
- R11: When several valid entries of a state carry the same byte, the lowest slot number wins.
- R12: An entry whose valid bit is 0 never matches, whatever its label.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_start | input | SW (5) | Start state used by reset, sop and error recovery |
| sop | input | 1 | Start-of-packet pulse |
| tbl_we | input | 1 | Table write strobe |
| tbl_kind | input | 1 | 0: labelled entry, 1: state header |
| tbl_state | input | SW (5) | State being written |
| tbl_slot | input | EW (3) | Entry slot being written |
| tbl_byte | input | 8 | Entry label |
| tbl_ptr | input | SW (5) | Entry successor or header fallback pointer |
| tbl_flag | input | 1 | Entry valid bit or header accepting flag |
| tbl_aux | input | 1 | Header fallback-present bit |
| in_valid | input | 1 | Input byte valid |
| in_byte | input | 8 | Input byte, held until accepted |
| in_ready | output | 1 | Byte consumed this cycle when in_valid is high |
| step_o | output | 1 | A byte was consumed in the previous cycle |
| match_o | output | 1 | Consumed byte led into an accepting state |
| state_o | output | SW (5) | Current automaton state |
| err_o | output | 1 | Sticky hop-limit or dead-end error |

## Verification
Several properties are checked on every cycle: the hop counter never passes its cap, the error flag never falls, a match only accompanies a consumed byte, each consumed byte traces back to a handshake, a stalled byte always advances the hop count by one, and sop always lands on the start state. Other behaviour can only be shown by the bench scenarios. These are equivalence with the uncompressed automaton over a random stream, the exact stall length of a multi-hop byte, the lowest-slot priority, dead entries, and recovery after an error. The same holds for writes that are ignored during a pending byte, since the table contents are visible only through later walks.

// File: rtl/d2fa_pkg.sv
// Package: shared types for the sparse-transition automaton walker.
// Assumes: the input alphabet is one byte wide.
package d2fa_pkg;
    typedef logic [7:0] sym_t;

    // Selects which part of a state record a table write updates.
    typedef enum logic {
        WR_ENTRY  = 1'b0,
        WR_HEADER = 1'b1
    } wr_kind_e;
endpackage

// File: rtl/d2fa_table.sv
// Module: d2fa_table
// Holds, for every state, NUM_ENTRIES labelled transitions (label, successor,
// valid) and a header (fallback pointer, fallback-present, accepting flag).
// One write port. The full row of rd_state and the accepting flags of all
// states are read combinationally.
// Assumes: the caller gates writes (no write/read hazard handling inside).
module d2fa_table
    import d2fa_pkg::*;
#(
    parameter int NUM_STATES  = 32,
    parameter int NUM_ENTRIES = 8,
    localparam int SW = $clog2(NUM_STATES),
    localparam int EW = $clog2(NUM_ENTRIES)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  wr_kind_e                       wr_kind,
    input  logic [SW-1:0]                  wr_state,
    input  logic [EW-1:0]                  wr_slot,
    input  sym_t                           wr_sym,
    input  logic [SW-1:0]                  wr_ptr,
    input  logic                           wr_flag,
    input  logic                           wr_aux,
    input  logic [SW-1:0]                  rd_state,
    output sym_t [NUM_ENTRIES-1:0]         rd_lbl,
    output logic [NUM_ENTRIES-1:0][SW-1:0] rd_nxt,
    output logic [NUM_ENTRIES-1:0]         rd_vld,
    output logic [SW-1:0]                  rd_fb,
    output logic                           rd_has_fb,
    output logic [NUM_STATES-1:0]          acc_vec
);
    sym_t [NUM_STATES-1:0][NUM_ENTRIES-1:0]          lbl_q;
    logic [NUM_STATES-1:0][NUM_ENTRIES-1:0][SW-1:0]  nxt_q;
    logic [NUM_STATES-1:0][NUM_ENTRIES-1:0]          vld_q;
    logic [NUM_STATES-1:0][SW-1:0]                   fb_q;
    logic [NUM_STATES-1:0]                           has_fb_q;
    logic [NUM_STATES-1:0]                           acc_q;

    // Storage update: clear on reset, otherwise apply one entry or header write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lbl_q    <= '0;
            nxt_q    <= '0;
            vld_q    <= '0;
            fb_q     <= '0;
            has_fb_q <= '0;
            acc_q    <= '0;
        end else if (wr_en) begin
            if (wr_kind == WR_ENTRY) begin
                lbl_q[wr_state][wr_slot] <= wr_sym;
                nxt_q[wr_state][wr_slot] <= wr_ptr;
                vld_q[wr_state][wr_slot] <= wr_flag;
            end else begin
                fb_q[wr_state]     <= wr_ptr;
                has_fb_q[wr_state] <= wr_aux;
                acc_q[wr_state]    <= wr_flag;
            end
        end
    end

    // Row read for the current state.
    always_comb begin
        rd_lbl    = lbl_q[rd_state];
        rd_nxt    = nxt_q[rd_state];
        rd_vld    = vld_q[rd_state];
        rd_fb     = fb_q[rd_state];
        rd_has_fb = has_fb_q[rd_state];
    end

    assign acc_vec = acc_q;
endmodule

// File: rtl/d2fa_slot_match.sv
// Module: d2fa_slot_match
// Compares one byte against every labelled entry of a row in parallel and
// returns the successor of the lowest-numbered valid entry that matches.
// Assumes: purely combinational, one row per cycle.
module d2fa_slot_match
    import d2fa_pkg::*;
#(
    parameter int NUM_ENTRIES = 8,
    parameter int SW          = 5
) (
    input  sym_t                           sym,
    input  sym_t [NUM_ENTRIES-1:0]         lbl,
    input  logic [NUM_ENTRIES-1:0][SW-1:0] nxt,
    input  logic [NUM_ENTRIES-1:0]         vld,
    output logic                           hit,
    output logic [SW-1:0]                  hit_nxt
);
    logic [NUM_ENTRIES-1:0] eq;

    // One comparator per slot.
    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_cmp
        assign eq[g] = vld[g] && (lbl[g] == sym);
    end

    // Priority pick: scan downward so that the lowest matching slot wins.
    always_comb begin
        hit     = 1'b0;
        hit_nxt = '0;
        for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
            if (eq[i]) begin
                hit     = 1'b1;
                hit_nxt = nxt[i];
            end
        end
    end
endmodule

// File: rtl/d2fa_engine.sv
// Module: d2fa_engine (top)
// Walks a fallback-compressed automaton over a valid/ready byte stream.
// A hit consumes the byte; a miss follows the fallback pointer and retries
// the same byte (input stalled); exceeding MAX_HOPS or a dead end drops the
// byte, sets a sticky error and restarts at cfg_start.
// Assumes: the source holds in_byte steady while in_valid is high and
// in_ready is low; fallback pointers form trees.
module d2fa_engine
    import d2fa_pkg::*;
#(
    parameter int NUM_STATES  = 32,
    parameter int NUM_ENTRIES = 8,
    parameter int MAX_HOPS    = 4,
    localparam int SW = $clog2(NUM_STATES),
    localparam int EW = $clog2(NUM_ENTRIES),
    localparam int HW = $clog2(MAX_HOPS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] cfg_start,
    input  logic          sop,
    input  logic          tbl_we,
    input  logic          tbl_kind,
    input  logic [SW-1:0] tbl_state,
    input  logic [EW-1:0] tbl_slot,
    input  logic [7:0]    tbl_byte,
    input  logic [SW-1:0] tbl_ptr,
    input  logic          tbl_flag,
    input  logic          tbl_aux,
    input  logic          in_valid,
    input  logic [7:0]    in_byte,
    output logic          in_ready,
    output logic          step_o,
    output logic          match_o,
    output logic [SW-1:0] state_o,
    output logic          err_o
);
    logic [SW-1:0]                  cur_q;
    logic [HW-1:0]                  hop_cnt;
    sym_t [NUM_ENTRIES-1:0]         row_lbl;
    logic [NUM_ENTRIES-1:0][SW-1:0] row_nxt;
    logic [NUM_ENTRIES-1:0]         row_vld;
    logic [SW-1:0]                  row_fb;
    logic                           row_has_fb;
    logic [NUM_STATES-1:0]          acc_vec;
    logic                           hit;
    logic [SW-1:0]                  hit_nxt;
    logic                           wr_ok;
    logic                           can_hop;
    logic                           abort;
    logic                           take;

    // Writes are accepted only while the walker is idle.
    assign wr_ok = tbl_we && !in_valid && (hop_cnt == '0) && !sop;

    d2fa_table #(
        .NUM_STATES  (NUM_STATES),
        .NUM_ENTRIES (NUM_ENTRIES)
    ) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_ok),
        .wr_kind   (wr_kind_e'(tbl_kind)),
        .wr_state  (tbl_state),
        .wr_slot   (tbl_slot),
        .wr_sym    (tbl_byte),
        .wr_ptr    (tbl_ptr),
        .wr_flag   (tbl_flag),
        .wr_aux    (tbl_aux),
        .rd_state  (cur_q),
        .rd_lbl    (row_lbl),
        .rd_nxt    (row_nxt),
        .rd_vld    (row_vld),
        .rd_fb     (row_fb),
        .rd_has_fb (row_has_fb),
        .acc_vec   (acc_vec)
    );

    d2fa_slot_match #(
        .NUM_ENTRIES (NUM_ENTRIES),
        .SW          (SW)
    ) u_match (
        .sym     (in_byte),
        .lbl     (row_lbl),
        .nxt     (row_nxt),
        .vld     (row_vld),
        .hit     (hit),
        .hit_nxt (hit_nxt)
    );

    // Decide between consume, hop and abort for the offered byte.
    always_comb begin
        can_hop  = !hit && row_has_fb && (hop_cnt < HW'(MAX_HOPS));
        abort    = !hit && !can_hop;
        in_ready = !sop && !wr_ok && (hit || abort);
        take     = in_valid && in_ready;
    end

    // Walk state, hop counter, result pulses and sticky error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q   <= cfg_start;
            hop_cnt <= '0;
            step_o  <= 1'b0;
            match_o <= 1'b0;
            err_o   <= 1'b0;
        end else begin
            step_o  <= take;
            match_o <= take && hit && acc_vec[hit_nxt];
            if (sop) begin
                cur_q   <= cfg_start;
                hop_cnt <= '0;
            end else if (in_valid) begin
                if (hit) begin
                    cur_q   <= hit_nxt;
                    hop_cnt <= '0;
                end else if (can_hop) begin
                    cur_q   <= row_fb;
                    hop_cnt <= hop_cnt + 1'b1;
                end else begin
                    cur_q   <= cfg_start;
                    hop_cnt <= '0;
                    err_o   <= 1'b1;
                end
            end
        end
    end

    assign state_o = cur_q;
endmodule

// File: rtl/d2fa_engine_chk.sv
// Module: d2fa_engine_chk
// Cycle-by-cycle properties of the walker, attached by bind below.
module d2fa_engine_chk #(
    parameter int SW       = 5,
    parameter int HW       = 3,
    parameter int MAX_HOPS = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic [SW-1:0] cfg_start,
    input logic          sop,
    input logic          in_valid,
    input logic          in_ready,
    input logic          step_o,
    input logic          match_o,
    input logic [SW-1:0] state_o,
    input logic          err_o,
    input logic [HW-1:0] hop_cnt
);
    assert_hop_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hop_cnt <= HW'(MAX_HOPS));

    assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o);

    assert_match_with_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |-> step_o);

    assert_step_from_take_R2: assert property (@(posedge clk) disable iff (!rst_n)
        step_o |-> $past(in_valid && in_ready));

    assert_stall_is_hop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_ready && !sop) |=> (hop_cnt == $past(hop_cnt) + 1'b1));

    assert_sop_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sop |=> (state_o == $past(cfg_start)) && !step_o);
endmodule

bind d2fa_engine d2fa_engine_chk #(
    .SW       (SW),
    .HW       (HW),
    .MAX_HOPS (MAX_HOPS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_start (cfg_start),
    .sop       (sop),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .step_o    (step_o),
    .match_o   (match_o),
    .state_o   (state_o),
    .err_o     (err_o),
    .hop_cnt   (hop_cnt)
);

// File: tb/test_d2fa_engine.sv
`timescale 1ns/1ps
// Bench for d2fa_engine: loads the a+ / b+c / c*d+ automaton in compressed
// form, walks a vector table and a random stream against an uncompressed
// model, then runs directed tests for hops, limits, priority and writes.
module test_d2fa_engine;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] cfg_start = 5'd0;
    logic       sop = 1'b0;
    logic       tbl_we = 1'b0;
    logic       tbl_kind = 1'b0;
    logic [4:0] tbl_state = '0;
    logic [2:0] tbl_slot = '0;
    logic [7:0] tbl_byte = '0;
    logic [4:0] tbl_ptr = '0;
    logic       tbl_flag = 1'b0;
    logic       tbl_aux = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_byte = '0;
    logic       in_ready, step_o, match_o, err_o;
    logic [4:0] state_o;

    int checks = 0;
    int errors = 0;

    // Vectors: {byte, expected state (4 bits), expected match (4 bits)}.
    localparam logic [15:0] VEC [9] = '{16'h6111, 16'h6220, 16'h6331,
        16'h6220, 16'h6220, 16'h6331, 16'h6441, 16'h6441, 16'h6111};

    d2fa_engine i_d2fa_engine (
        .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .sop(sop),
        .tbl_we(tbl_we), .tbl_kind(tbl_kind), .tbl_state(tbl_state),
        .tbl_slot(tbl_slot), .tbl_byte(tbl_byte), .tbl_ptr(tbl_ptr),
        .tbl_flag(tbl_flag), .tbl_aux(tbl_aux), .in_valid(in_valid),
        .in_byte(in_byte), .in_ready(in_ready), .step_o(step_o),
        .match_o(match_o), .state_o(state_o), .err_o(err_o));

    always #4 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Uncompressed model: states 0 idle, 1 after a, 2 after b, 3 after bc, 4 after d.
    function automatic int ref_next(input int s, input logic [7:0] b);
        case (b)
            8'h61:   return 1;
            8'h62:   return 2;
            8'h63:   return (s == 2) ? 3 : 0;
            default: return 4;
        endcase
    endfunction

    function automatic int ref_acc(input int s);
        return (s == 1 || s == 3 || s == 4) ? 1 : 0;
    endfunction

    task automatic wr_entry(input int st, input int slot, input logic [7:0] b,
                            input int ptr, input bit v);
        @(negedge clk);
        tbl_we = 1'b1; tbl_kind = 1'b0; tbl_state = 5'(st); tbl_slot = 3'(slot);
        tbl_byte = b; tbl_ptr = 5'(ptr); tbl_flag = v; tbl_aux = 1'b0;
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    task automatic wr_hdr(input int st, input int fb, input bit has_fb, input bit acc);
        @(negedge clk);
        tbl_we = 1'b1; tbl_kind = 1'b1; tbl_state = 5'(st); tbl_ptr = 5'(fb);
        tbl_aux = has_fb; tbl_flag = acc;
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    task automatic pulse_sop(input int st);
        @(negedge clk);
        cfg_start = 5'(st); sop = 1'b1;
        @(negedge clk);
        sop = 1'b0;
    endtask

    // Offer one byte; optionally try a table write while it is stalled.
    // Returns at the negedge after consumption with cycles offered in cyc.
    task automatic send(input logic [7:0] b, input bit inj, output int cyc);
        bit r;
        @(negedge clk);
        in_valid = 1'b1; in_byte = b; cyc = 0;
        forever begin
            if (inj && cyc == 1) begin
                tbl_we = 1'b1; tbl_kind = 1'b0; tbl_state = 5'd14; tbl_slot = 3'd0;
                tbl_byte = 8'h78; tbl_ptr = 5'd0; tbl_flag = 1'b1;
            end else begin
                tbl_we = 1'b0;
            end
            #1 r = in_ready;
            @(posedge clk);
            cyc++;
            @(negedge clk);
            if (r) break;
        end
        in_valid = 1'b0; tbl_we = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int cyc;
        int ms;
        logic [15:0] lfsr;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 state", state_o, 0);
        chk("R1 match", match_o, 0);
        chk("R1 step", step_o, 0);
        chk("R1 err", err_o, 0);

        // R10 load compressed automaton: root 0 full, others fall back to 0.
        wr_entry(0, 0, 8'h61, 1, 1); wr_entry(0, 1, 8'h62, 2, 1);
        wr_entry(0, 2, 8'h63, 0, 1); wr_entry(0, 3, 8'h64, 4, 1);
        wr_hdr(0, 0, 0, 0);
        wr_hdr(1, 0, 1, 1);
        wr_entry(2, 0, 8'h63, 3, 1); wr_hdr(2, 0, 1, 0);
        wr_hdr(3, 0, 1, 1);
        wr_hdr(4, 0, 1, 1);
        // Hop chain 9->10->11->12->13->14 (root, x->10).
        wr_entry(14, 0, 8'h78, 10, 1); wr_hdr(14, 0, 0, 0);
        wr_hdr(13, 14, 1, 0); wr_hdr(12, 13, 1, 0); wr_hdr(11, 12, 1, 0);
        wr_hdr(10, 11, 1, 1); wr_hdr(9, 10, 1, 0);
        // Priority / dead-entry state 20 (root).
        wr_entry(20, 1, 8'h70, 1, 1); wr_entry(20, 5, 8'h70, 2, 1);
        wr_entry(20, 3, 8'h71, 3, 0); wr_hdr(20, 0, 0, 0);

        // R2 R4 R5 vector table walk
        pulse_sop(0);
        for (int i = 0; i < 9; i++) begin
            send(VEC[i][15:8], 1'b0, cyc);
            chk("R2 R5 vector state", state_o, int'(VEC[i][7:4]));
            chk("R4 vector match", match_o, int'(VEC[i][3:0]));
            chk("R4 vector step", step_o, 1);
        end

        // R5 random stream over {a,b,c,d}
        pulse_sop(0);
        ms = 0;
        lfsr = 16'hACE1;
        for (int i = 0; i < 400; i++) begin
            logic [7:0] b;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            b = 8'h61 + {6'd0, lfsr[1:0]};
            ms = ref_next(ms, b);
            send(b, 1'b0, cyc);
            chk("R5 random state", state_o, ms);
            chk("R5 random match", match_o, ref_acc(ms));
        end

        // R8 sop mid-stream: after b, sop to 0, then c must not match.
        send(8'h62, 1'b0, cyc);
        chk("R8 pre state", state_o, 2);
        pulse_sop(0);
        chk("R8 sop state", state_o, 0);
        send(8'h63, 1'b0, cyc);
        chk("R8 after sop state", state_o, 0);
        chk("R8 after sop match", match_o, 0);

        // R3 four hops then consume: 5 cycles offered.
        pulse_sop(10);
        send(8'h78, 1'b0, cyc);
        chk("R3 cycles for 4 hops", cyc, 5);
        chk("R3 state", state_o, 10);
        chk("R4 match after hops", match_o, 1);
        chk("R6 no error at limit", err_o, 0);

        // R9 write during stall is ignored.
        send(8'h78, 1'b1, cyc);
        chk("R9 state", state_o, 10);
        chk("R9 match", match_o, 1);
        pulse_sop(10);
        send(8'h78, 1'b0, cyc);
        chk("R9 table unchanged", state_o, 10);

        // R11 lowest slot wins.
        pulse_sop(20);
        send(8'h70, 1'b0, cyc);
        chk("R11 priority state", state_o, 1);
        chk("R11 err", err_o, 0);

        // R12 R7 dead entry at a root: drop, error, back to start.
        pulse_sop(20);
        send(8'h71, 1'b0, cyc);
        chk("R12 R7 state", state_o, 20);
        chk("R12 R7 err", err_o, 1);
        chk("R7 match", match_o, 0);

        // R6 five hops needed: abort to cfg_start, resume with next byte.
        pulse_sop(9);
        @(negedge clk);
        cfg_start = 5'd0;
        send(8'h78, 1'b0, cyc);
        chk("R6 abort state", state_o, 0);
        chk("R6 abort match", match_o, 0);
        chk("R6 abort step", step_o, 1);
        chk("R6 err sticky", err_o, 1);
        send(8'h61, 1'b0, cyc);
        chk("R6 resume state", state_o, 1);
        chk("R6 resume match", match_o, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule